// File: doc/BRIEF.md
# Power-On and Pin Reset Sequencer

This block merges three reset causes into a single internal active-low reset: a power-on indication from an analog detector, a supply-good indication from a low-voltage detector, and an external active-low reset pin. It runs on an always-on reference clock. Every duration is a cycle count set by a parameter. After the power-on indication goes away, the block holds the internal reset for a fixed initialisation interval. The reset is released only when that interval has ended, the reset pin reads high and the supply is reported good. A supply dip that the detector flags holds the block in reset. After the detector clears, a separate settling interval must also elapse before release.

While the chip is running, a low level on the reset pin causes a warm reset only if it lasts at least a minimum number of cycles. Shorter glitches are dropped. The pin, the boot-select input and the supply-good input each pass through a two-flop synchroniser before any decision uses them. Each time reset is released, the block latches two outputs. The first is a cold/warm flag: cold for a power-on or supply cause, warm for a pin-only cause. The second is a boot-select bit, set when the boot input is low at the moment of release.

Top module: `rstseq_top`

## Requirements
- R1: After `por_n` rises, `sys_rst_n` stays low for at least `INIT_CYCLES` clock cycles.
- R2: If the synchronised reset pin is still low when the initialisation interval ends, `sys_rst_n` stays low until the pin reads high. It rises within 4 cycles of the pin going high.
- R3: A reset pin that returns high before the initialisation interval ends does not shorten the interval. Release still happens only after it.
- R4: If `lvd_ok` is low, `sys_rst_n` is held low. After `lvd_ok` returns high, release waits a further `LVD_REL_CYCLES` cycles.
- R5: When `lvd_ok` falls while running, `sys_rst_n` goes low within 4 cycles. It is then released under R4.
- R6: While running, if `rst_pin_n` stays low for at least `PIN_MIN_CYCLES` consecutive cycles, `sys_rst_n` goes low. It goes high again within 4 cycles of the pin returning high.
- R7: A low pulse on `rst_pin_n` shorter than `PIN_MIN_CYCLES` cycles leaves `sys_rst_n` high.
- R8: At each release, `boot_single` takes the value 1 if `boot_pin_n` was low, and 0 if it was high. It holds that value until the next release. Its value during power-on reset is 0.
- R9: At each release, `cold_flag` becomes 1 if the reset episode began with power-on or a supply fault, and 0 if it began with a qualified pin pulse. It holds that value until the next release. Its value during power-on reset is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| por_n | input | 1 | Power-on indication, active low, asynchronous |
| lvd_ok | input | 1 | Supply-good indication from the low-voltage detector |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| boot_pin_n | input | 1 | Boot-select pin, low selects single-boot mode |
| sys_rst_n | output | 1 | Internal reset, active low, registered |
| cold_flag | output | 1 | 1 when the last release followed a cold reset, 0 after a warm one |
| boot_single | output | 1 | Boot mode latched at the last release |

## Verification
The hardest situation to reach is the boundary of the pin pulse qualifier while the block is running. A glitch just under the minimum width must be dropped, and one just over it must start a warm reset that later reports a warm cause. The stimulus first drives directed pulses a few cycles either side of the threshold. It then drives seeded random widths from both sides, each with a random boot level. A monitor records whether the internal reset dipped at any point in each window. Supply-fault and pin-held cases are arranged by holding the detector or the pin low across a power-on release.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [2:0] {
    ST_INIT = 3'd0,
    ST_LVDW = 3'd1,
    ST_LVDR = 3'd2,
    ST_PINW = 3'd3,
    ST_RUN  = 3'd4,
    ST_WARM = 3'd5
  } seq_st_t;
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
  parameter int            CW       = 8,
  parameter logic [CW-1:0] RST_LOAD = '0
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) cnt_q <= RST_LOAD;
    else         cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/rstseq_pinqual.sv
module rstseq_pinqual #(
  parameter int MIN_LOW = 20,
  localparam int QW = $clog2(MIN_LOW + 1)
) (
  input  logic clk,
  input  logic arst_n,
  input  logic pin_s,
  output logic hit
);
  logic [QW-1:0] run_q, run_d;

  always_comb begin
    run_d = run_q;
    if (pin_s)                       run_d = '0;
    else if (run_q != QW'(MIN_LOW))  run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) run_q <= '0;
    else         run_q <= run_d;
  end

  assign hit = !pin_s && (run_q == QW'(MIN_LOW - 1));
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int INIT_CYCLES    = 1024,
  parameter int LVD_REL_CYCLES = 512,
  parameter int PIN_MIN_CYCLES = 64,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic lvd_ok,
  input  logic rst_pin_n,
  input  logic boot_pin_n,
  output logic sys_rst_n,
  output logic cold_flag,
  output logic boot_single
);
  localparam int TMAX = (INIT_CYCLES > LVD_REL_CYCLES) ? INIT_CYCLES : LVD_REL_CYCLES;
  localparam int CW   = $clog2(TMAX + 1);

  logic    arst_n;
  logic    lvd_s, pin_s, boot_s;
  logic    tmr_load, tmr_done, pin_hit;
  seq_st_t st_q, st_d;
  logic    kind_q, kind_d;
  logic    rel_q, rel_d;
  logic    cold_q, cold_d;
  logic    boot_q, boot_d;

  // reset: asserted with por_n, released on the clock
  rstseq_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_por_sync (
    .clk(clk), .arst_n(por_n), .d(1'b1), .q(arst_n)
  );

  rstseq_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b000)) u_in_sync (
    .clk(clk), .arst_n(arst_n),
    .d({lvd_ok, rst_pin_n, boot_pin_n}),
    .q({lvd_s, pin_s, boot_s})
  );

  assign tmr_load = (st_q == ST_LVDW) && lvd_s;

  rstseq_timer #(.CW(CW), .RST_LOAD(CW'(INIT_CYCLES))) u_timer (
    .clk(clk), .arst_n(arst_n), .load(tmr_load),
    .load_val(CW'(LVD_REL_CYCLES)), .done(tmr_done)
  );

  rstseq_pinqual #(.MIN_LOW(PIN_MIN_CYCLES)) u_qual (
    .clk(clk), .arst_n(arst_n), .pin_s(pin_s), .hit(pin_hit)
  );

  // next-state logic
  always_comb begin
    st_d   = st_q;
    kind_d = kind_q;
    unique case (st_q)
      ST_INIT: if (tmr_done) begin
        if (!lvd_s)      st_d = ST_LVDW;
        else if (!pin_s) st_d = ST_PINW;
        else             st_d = ST_RUN;
      end
      ST_LVDW: if (lvd_s) st_d = ST_LVDR;
      ST_LVDR: begin
        if (!lvd_s)         st_d = ST_LVDW;
        else if (tmr_done)  st_d = pin_s ? ST_RUN : ST_PINW;
      end
      ST_PINW: begin
        if (!lvd_s)     st_d = ST_LVDW;
        else if (pin_s) st_d = ST_RUN;
      end
      ST_RUN: begin
        if (!lvd_s) begin
          st_d   = ST_LVDW;
          kind_d = 1'b1;
        end else if (pin_hit) begin
          st_d   = ST_WARM;
          kind_d = 1'b0;
        end
      end
      ST_WARM: begin
        if (!lvd_s) begin
          st_d   = ST_LVDW;
          kind_d = 1'b1;
        end else if (pin_s) begin
          st_d = ST_RUN;
        end
      end
      default: st_d = ST_INIT;
    endcase
    if (st_d == ST_LVDW) kind_d = 1'b1;
  end

  always_comb begin
    rel_d  = (st_d == ST_RUN);
    cold_d = cold_q;
    boot_d = boot_q;
    if ((st_d == ST_RUN) && (st_q != ST_RUN)) begin
      cold_d = kind_q;
      boot_d = !boot_s;
    end
  end

  // registers
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q   <= ST_INIT;
      kind_q <= 1'b1;
      rel_q  <= 1'b0;
      cold_q <= 1'b1;
      boot_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
      rel_q  <= rel_d;
      cold_q <= cold_d;
      boot_q <= boot_d;
    end
  end

  assign sys_rst_n   = rel_q;
  assign cold_flag   = cold_q;
  assign boot_single = boot_q;
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
  parameter int INIT_CYCLES    = 1024,
  parameter int PIN_MIN_CYCLES = 64
) (
  input logic clk,
  input logic arst_n,
  input logic lvd_s,
  input logic pin_s,
  input logic sys_rst_n,
  input logic cold_flag,
  input logic boot_single
);
  localparam int SW = $clog2(INIT_CYCLES + 1);
  localparam int LW = $clog2(PIN_MIN_CYCLES + 1);

  logic [SW-1:0] since_q;
  logic [LW-1:0] low_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      since_q <= '0;
      low_q   <= '0;
    end else begin
      if (since_q != SW'(INIT_CYCLES)) since_q <= since_q + 1'b1;
      if (pin_s) low_q <= '0;
      else if (low_q != LW'(PIN_MIN_CYCLES)) low_q <= low_q + 1'b1;
    end
  end

  p_init_hold_r1: assert property (@(posedge clk) disable iff (!arst_n)
    (since_q < SW'(INIT_CYCLES)) |-> !sys_rst_n);

  p_pin_high_r2: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(sys_rst_n) |-> $past(pin_s));

  p_supply_ok_r4: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(sys_rst_n) |-> $past(lvd_s));

  p_supply_drop_r5: assert property (@(posedge clk) disable iff (!arst_n)
    !lvd_s |=> !sys_rst_n);

  p_glitch_drop_r7: assert property (@(posedge clk) disable iff (!arst_n)
    ($fell(sys_rst_n) && $past(lvd_s)) |-> (int'($past(low_q)) >= PIN_MIN_CYCLES - 1));

  p_flags_hold_r9: assert property (@(posedge clk) disable iff (!arst_n)
    (sys_rst_n && $past(sys_rst_n)) |-> ($stable(cold_flag) && $stable(boot_single)));
endmodule

bind rstseq_top rstseq_chk #(
  .INIT_CYCLES(INIT_CYCLES),
  .PIN_MIN_CYCLES(PIN_MIN_CYCLES)
) u_chk (
  .clk(clk), .arst_n(arst_n), .lvd_s(lvd_s), .pin_s(pin_s),
  .sys_rst_n(sys_rst_n), .cold_flag(cold_flag), .boot_single(boot_single)
);

// File: tb/rstseq_top_test.sv
module rstseq_top_test;
  localparam int I = 40;
  localparam int L = 25;
  localparam int M = 20;

  logic clk = 1'b0;
  logic por_n, lvd_ok, rst_pin_n, boot_pin_n;
  logic sys_rst_n, cold_flag, boot_single;
  int   checks = 0;
  int   fails  = 0;
  logic saw_low = 1'b0;

  always #2 clk = ~clk;

  rstseq_top #(.INIT_CYCLES(I), .LVD_REL_CYCLES(L), .PIN_MIN_CYCLES(M)) uut (
    .clk(clk), .por_n(por_n), .lvd_ok(lvd_ok), .rst_pin_n(rst_pin_n),
    .boot_pin_n(boot_pin_n), .sys_rst_n(sys_rst_n), .cold_flag(cold_flag),
    .boot_single(boot_single)
  );

  always @(negedge clk) if (!sys_rst_n) saw_low = 1'b1;

  function automatic bit exp_reset(int w);
    return (w >= M);
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic por_cycle();
    por_n = 1'b0;
    tick(3);
    por_n = 1'b1;
  endtask

  initial begin
    int dummy;
    dummy = $urandom(32'd4711);
    por_n = 1'b0; lvd_ok = 1'b1; rst_pin_n = 1'b1; boot_pin_n = 1'b1;
    tick(5);
    // reset state
    check(sys_rst_n == 1'b0, "R1 reset state", sys_rst_n, 0);
    check(cold_flag == 1'b1, "R9 reset value", cold_flag, 1);
    check(boot_single == 1'b0, "R8 reset value", boot_single, 0);

    // R1: plain power-on
    por_n = 1'b1;
    tick(30);
    check(sys_rst_n == 1'b0, "R1 inside interval", sys_rst_n, 0);
    tick(20);
    check(sys_rst_n == 1'b1, "R1 released", sys_rst_n, 1);
    check(cold_flag == 1'b1, "R9 cold after power-on", cold_flag, 1);
    check(boot_single == 1'b0, "R8 boot high", boot_single, 0);

    // R3: pin rises early, interval still honoured
    rst_pin_n = 1'b0;
    por_cycle();
    tick(10);
    rst_pin_n = 1'b1;
    tick(22);
    check(sys_rst_n == 1'b0, "R3 early pin", sys_rst_n, 0);
    tick(20);
    check(sys_rst_n == 1'b1, "R3 released", sys_rst_n, 1);

    // R2: pin held past interval, boot low
    rst_pin_n = 1'b0; boot_pin_n = 1'b0;
    por_cycle();
    tick(80);
    check(sys_rst_n == 1'b0, "R2 pin held", sys_rst_n, 0);
    rst_pin_n = 1'b1;
    tick(5);
    check(sys_rst_n == 1'b1, "R2 released", sys_rst_n, 1);
    check(boot_single == 1'b1, "R8 boot low", boot_single, 1);
    check(cold_flag == 1'b1, "R9 cold after pin-held power-on", cold_flag, 1);
    boot_pin_n = 1'b1;

    // R4: supply not good at power-on
    lvd_ok = 1'b0;
    por_cycle();
    tick(100);
    check(sys_rst_n == 1'b0, "R4 supply low", sys_rst_n, 0);
    lvd_ok = 1'b1;
    tick(20);
    check(sys_rst_n == 1'b0, "R4 settling", sys_rst_n, 0);
    tick(15);
    check(sys_rst_n == 1'b1, "R4 released", sys_rst_n, 1);

    // R6/R7: directed boundary then seeded random pulse widths
    for (int k = 0; k < 18; k++) begin
      int w;
      bit b;
      bit exp;
      if (k == 0)      w = M - 3;
      else if (k == 1) w = M + 3;
      else if (($urandom % 2) == 1) w = M + 4 + int'($urandom % 30);
      else             w = 1 + int'($urandom % (M - 4));
      b   = 1'($urandom % 2);
      exp = exp_reset(w);
      boot_pin_n = b;
      tick(2);
      saw_low = 1'b0;
      rst_pin_n = 1'b0;
      tick(w);
      rst_pin_n = 1'b1;
      tick(10);
      if (exp)
        check(saw_low == 1'b1, "R6 long pulse resets", saw_low, 1);
      else
        check(saw_low == 1'b0, "R7 short pulse ignored", saw_low, 0);
      check(sys_rst_n == 1'b1, "R6 released after pin high", sys_rst_n, 1);
      if (exp) begin
        check(cold_flag == 1'b0, "R9 warm cause", cold_flag, 0);
        check(boot_single == !b, "R8 boot latched", boot_single, !b);
      end
    end

    // R5: supply drop while running, cause turns cold
    lvd_ok = 1'b0;
    tick(4);
    check(sys_rst_n == 1'b0, "R5 supply drop", sys_rst_n, 0);
    lvd_ok = 1'b1;
    tick(40);
    check(sys_rst_n == 1'b1, "R5 recovered", sys_rst_n, 1);
    check(cold_flag == 1'b1, "R9 cold after supply drop", cold_flag, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule